// File: doc/BRIEF.md
# Serial Single-Error-Correcting Cyclic Decoder (7,4)

This block corrects a serial stream of words from a systematic (7,4) cyclic Hamming code, generator x^3 + x + 1, minimum distance 3. Received bits arrive one per clock, highest-order coefficient first. Each bit is stored in a seven-stage holding register. The same bit also enters a three-stage syndrome register. That register divides the received polynomial, after multiplying it by x^3, by the generator. Because of this premultiplication, an error in whichever bit is leaving the block shows one fixed syndrome value. The correction decision is therefore a single comparison, made as each bit leaves.

Once a word is complete, its held bits shift out on consecutive clocks while its syndrome register keeps cycling. When the syndrome matches the fixed pattern, the outgoing bit is inverted and the pattern is removed from the syndrome. Two identical lanes work in turn. One lane drains the previous word while the other fills with the next, so the output runs exactly one word behind the input and the input may stream without pause.

Each lane runs a three-state machine. IDLE moves to FILL on a word-start bit. FILL loops back to itself on every bit, and a word-start bit restarts the word there. FILL moves to DRAIN on the seventh bit. DRAIN moves to IDLE after the seventh output bit.

Top module: `meggitt_decoder`

## Requirements
- R1: A synchronous active-high reset puts every lane in IDLE, discards any partial word, keeps out_valid low in the following cycle and sends the next word to lane 0.
- R2: A word opens on a cycle with in_valid and in_sof both high. The next six cycles with in_valid high complete it. Cycles with in_valid high while no word is open are ignored and produce no output.
- R3: in_sof with in_valid while a word is partly received discards the partial word, and the bit on that cycle becomes bit 6 of a new word.
- R4: The first output bit appears in the cycle after the seventh input bit is taken. out_valid then stays high for seven consecutive cycles, in the same order as arrival (bit 6 first). out_sof is high on the first of these cycles and out_eow on the last.
- R5: A valid codeword (the received polynomial is divisible by x^3 + x + 1) leaves unchanged, with out_fixed low on every bit.
- R6: A word with exactly one inverted bit, at any of the seven positions, leaves as the original codeword. out_fixed is high on that bit only. The lane compares its syndrome with 3'b100 (bit 2 set), the premultiplied syndrome of an error in the outgoing bit.
- R7: A new word may fill while the previous word drains, with or without idle cycles between input bits. Words come out in arrival order, and no two lanes drive the output in the same cycle.
- R8: A received word that is not a codeword always has exactly one bit inverted: the bit whose inversion yields a codeword. This also applies when two bits were in error, in which case the result is a wrong codeword.
- R9: out_uncorr is high together with out_eow only when the syndrome is still nonzero after the last correction. With this generator every nonzero syndrome matches one position, so out_uncorr stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_bit carries a received bit this cycle |
| in_sof | input | 1 | Marks the first bit of a word (with in_valid) |
| in_bit | input | 1 | Received bit, highest order first |
| out_valid | output | 1 | out_bit carries a decoded bit |
| out_sof | output | 1 | First output bit of a word |
| out_eow | output | 1 | Last output bit of a word |
| out_bit | output | 1 | Corrected bit |
| out_fixed | output | 1 | This bit was inverted by the decoder |
| out_uncorr | output | 1 | Residual syndrome nonzero at end of word (with out_eow) |

## Verification
The assertions assume that a lane never gets a word-start while it drains. This holds because a word needs at least seven input cycles, while a drain takes exactly seven, so the lane chosen for filling is always idle or filling. The assertions also assume that reset is not raised on the first clock before the design's registers hold known values. The stimulus respects both points. Every word it sends takes at least seven cycles, including words cut short by a restart. It holds reset high from time zero and applies a later reset only once the output has gone quiet.

// File: rtl/meggitt_pkg.sv
package meggitt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } lane_state_t;

    typedef struct packed {
        logic valid;
        logic sof;
        logic eow;
        logic data;
        logic fixed;
        logic uncorr;
    } lane_out_t;

endpackage

// File: rtl/meggitt_lane.sv
module meggitt_lane
    import meggitt_pkg::*;
#(
    parameter int N = 7,
    parameter int P = 3,
    parameter logic [P-1:0] GLOW = 3'b011
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fill_en,
    input  logic      sof,
    input  logic      din,
    output logic      done,
    output lane_out_t lo
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    function automatic logic [P-1:0] mul_x(input logic [P-1:0] s);
        mul_x = {s[P-2:0], 1'b0} ^ (s[P-1] ? GLOW : '0);
    endfunction

    function automatic logic [P-1:0] absorb(input logic [P-1:0] s, input logic b);
        logic fb;
        fb = s[P-1] ^ b;
        absorb = {s[P-2:0], 1'b0} ^ (fb ? GLOW : '0);
    endfunction

    function automatic logic [P-1:0] x_pow(input int e);
        logic [P-1:0] r;
        r = P'(1);
        for (int i = 0; i < e; i++) r = mul_x(r);
        x_pow = r;
    endfunction

    // syndrome of an error in the bit that is about to leave
    localparam logic [P-1:0] HIT_PAT = x_pow(N - 1 + P);

    lane_state_t   state, nstate;
    logic [CW-1:0] cnt;
    logic [P-1:0]  syn;
    logic [N-1:0]  hold;
    logic          hit;
    logic [P-1:0]  syn_after;

    assign hit       = (state == ST_DRAIN) && (syn == HIT_PAT);
    assign syn_after = mul_x(syn ^ (hit ? HIT_PAT : '0));
    assign done      = (state == ST_FILL) && fill_en && !sof && (cnt == LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (fill_en && sof) nstate = ST_FILL;
            ST_FILL:  if (fill_en && !sof && cnt == LAST) nstate = ST_DRAIN;
            ST_DRAIN: if (cnt == LAST) nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // datapath: holding register, syndrome register, bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            syn  <= '0;
            hold <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (fill_en && sof) begin
                        syn  <= absorb('0, din);
                        hold <= {{(N-1){1'b0}}, din};
                        cnt  <= CW'(1);
                    end
                end
                ST_FILL: begin
                    if (fill_en) begin
                        if (sof) begin
                            syn  <= absorb('0, din);
                            hold <= {{(N-1){1'b0}}, din};
                            cnt  <= CW'(1);
                        end else begin
                            syn  <= absorb(syn, din);
                            hold <= {hold[N-2:0], din};
                            cnt  <= (cnt == LAST) ? '0 : cnt + CW'(1);
                        end
                    end
                end
                ST_DRAIN: begin
                    syn  <= syn_after;
                    hold <= {hold[N-2:0], 1'b0};
                    cnt  <= (cnt == LAST) ? '0 : cnt + CW'(1);
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        lo        = '0;
        lo.valid  = (state == ST_DRAIN);
        lo.sof    = (state == ST_DRAIN) && (cnt == '0);
        lo.eow    = (state == ST_DRAIN) && (cnt == LAST);
        lo.data   = (state == ST_DRAIN) && (hold[N-1] ^ hit);
        lo.fixed  = hit;
        lo.uncorr = (state == ST_DRAIN) && (cnt == LAST) && (syn_after != '0);
    end

    p_drain_len_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && cnt == LAST) |=> (state == ST_IDLE));

    p_drain_cont_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && cnt != LAST) |=> (state == ST_DRAIN));

    p_no_start_in_drain_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |-> !(fill_en && sof));

    p_residual_r9: assert property (@(posedge clk) disable iff (rst)
        (lo.eow && !lo.uncorr) |=> (syn == '0));

    p_fill_to_drain_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> (state == ST_DRAIN && cnt == '0));

endmodule

// File: rtl/meggitt_merge.sv
module meggitt_merge
    import meggitt_pkg::*;
#(
    parameter int NL = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  lane_out_t lanes [NL],
    output lane_out_t merged
);
    logic [NL-1:0] vld;

    always_comb begin
        merged = '0;
        for (int i = 0; i < NL; i++) begin
            vld[i] = lanes[i].valid;
            if (lanes[i].valid) merged = merged | lanes[i];
        end
    end

    p_one_lane_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(vld));

endmodule

// File: rtl/meggitt_decoder.sv
module meggitt_decoder
    import meggitt_pkg::*;
#(
    parameter int N  = 7,
    parameter int P  = 3,
    parameter logic [P-1:0] GLOW = 3'b011,
    parameter int NL = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_bit,
    output logic out_valid,
    output logic out_sof,
    output logic out_eow,
    output logic out_bit,
    output logic out_fixed,
    output logic out_uncorr
);
    localparam int SW = (NL > 1) ? $clog2(NL) : 1;
    localparam logic [SW-1:0] LAST_LANE = SW'(NL - 1);

    logic [SW-1:0] fill_sel;
    logic [NL-1:0] done;
    lane_out_t     lane_o [NL];
    lane_out_t     merged;

    generate
        for (genvar g = 0; g < NL; g++) begin : g_lane
            meggitt_lane #(.N(N), .P(P), .GLOW(GLOW)) u_lane (
                .clk     (clk),
                .rst     (rst),
                .fill_en (in_valid && (fill_sel == SW'(g))),
                .sof     (in_sof),
                .din     (in_bit),
                .done    (done[g]),
                .lo      (lane_o[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) fill_sel <= '0;
        else if (done[fill_sel]) fill_sel <= (fill_sel == LAST_LANE) ? '0 : fill_sel + SW'(1);
    end

    meggitt_merge #(.NL(NL)) u_merge (
        .clk    (clk),
        .rst    (rst),
        .lanes  (lane_o),
        .merged (merged)
    );

    assign out_valid  = merged.valid;
    assign out_sof    = merged.sof;
    assign out_eow    = merged.eow;
    assign out_bit    = merged.data;
    assign out_fixed  = merged.fixed;
    assign out_uncorr = merged.uncorr;

    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !out_valid);

    p_flags_qualified_r4: assert property (@(posedge clk) disable iff (rst)
        (out_sof || out_eow || out_fixed || out_uncorr) |-> out_valid);

    p_uncorr_at_end_r9: assert property (@(posedge clk) disable iff (rst)
        out_uncorr |-> out_eow);

    p_word_runs_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eow) |=> (out_valid && !out_sof));

endmodule

// File: tb/meggitt_decoder_tb.sv
module meggitt_decoder_tb;

    typedef struct packed {
        logic sof;
        logic eow;
        logic data;
        logic fixed;
        logic uncorr;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_sof = 1'b0, in_bit = 1'b0;
    logic out_valid, out_sof, out_eow, out_bit, out_fixed, out_uncorr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    string tag = "R1";

    exp_t exp_q[$];
    bit   w_open = 0;
    int   w_cnt = 0;
    int   w_val = 0;
    int   lfsr = 32'h1ACE;

    always #10 clk = ~clk;

    meggitt_decoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_bit(in_bit),
        .out_valid(out_valid), .out_sof(out_sof), .out_eow(out_eow), .out_bit(out_bit),
        .out_fixed(out_fixed), .out_uncorr(out_uncorr)
    );

    function automatic int rem7(input int w);
        int r;
        r = w;
        for (int i = 6; i >= 3; i--) if (r[i]) r = r ^ (11 << (i - 3));
        return r & 7;
    endfunction

    function automatic int encode(input int d);
        return ((d & 15) << 3) | rem7((d & 15) << 3);
    endfunction

    function automatic int nearest(input int w);
        if (rem7(w) == 0) return w;
        for (int j = 0; j < 7; j++) if (rem7(w ^ (1 << j)) == 0) return w ^ (1 << j);
        return w;
    endfunction

    task automatic push_word(input int w);
        int c;
        exp_t e;
        c = nearest(w);
        for (int k = 6; k >= 0; k--) begin
            e.sof = (k == 6); e.eow = (k == 0); e.data = c[k];
            e.fixed = (c[k] != w[k]); e.uncorr = 1'b0;
            exp_q.push_back(e);
        end
    endtask

    task automatic check_out();
        exp_t e;
        checks++;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            if (!(out_valid && out_sof == e.sof && out_eow == e.eow && out_bit == e.data &&
                  out_fixed == e.fixed && out_uncorr == e.uncorr)) begin
                errors++;
                $display("FAIL %s: got v=%b s=%b e=%b d=%b f=%b u=%b exp v=1 s=%b e=%b d=%b f=%b u=%b",
                         tag, out_valid, out_sof, out_eow, out_bit, out_fixed, out_uncorr,
                         e.sof, e.eow, e.data, e.fixed, e.uncorr);
            end
        end else if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: got out_valid=%b exp 0", tag, out_valid);
        end
    endtask

    // one clock: check outputs, then drive inputs and update the model
    task automatic tick(input bit r, input bit v, input bit s, input bit b);
        @(negedge clk);
        check_out();
        rst = r; in_valid = v; in_sof = s; in_bit = b;
        if (r) begin
            w_open = 0; w_cnt = 0;
        end else if (v) begin
            if (s) begin
                w_open = 1; w_cnt = 1; w_val = b;
            end else if (w_open) begin
                w_val = (w_val << 1) | b; w_cnt++;
                if (w_cnt == 7) begin
                    push_word(w_val); w_open = 0;
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0);
    endtask

    function automatic int rnd();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        return lfsr;
    endfunction

    task automatic send_word(input int w, input bit gaps);
        for (int k = 6; k >= 0; k--) begin
            if (gaps) for (int g = 0; g < (rnd() % 3); g++) tick(0, 0, 0, 0);
            tick(0, 1, k == 6, w[k]);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        for (int i = 0; i < 4; i++) tick(1, 0, 0, 0);
        idle(3);

        // R5: clean codewords back to back (also R7 streaming)
        tag = "R5";
        for (int d = 0; d < 16; d++) send_word(encode(d), 0);
        idle(10);

        // R6: every single-bit error position
        tag = "R6";
        for (int d = 0; d < 16; d++)
            for (int j = 0; j < 7; j++) send_word(encode(d) ^ (1 << j), 0);
        idle(10);

        // R7: idle gaps between input bits while previous words drain
        tag = "R7";
        for (int i = 0; i < 40; i++) send_word(encode(rnd()) ^ ((rnd() % 2) ? (1 << (rnd() % 7)) : 0), 1);
        idle(10);

        // R8: double errors are miscorrected to the nearest codeword
        tag = "R8";
        for (int i = 0; i < 20; i++) send_word(encode(i) ^ (1 << (i % 7)) ^ (1 << ((i + 3) % 7)), 0);
        idle(10);

        // R3: restart in the middle of a word
        tag = "R3";
        tick(0, 1, 1, 1); tick(0, 1, 0, 0); tick(0, 1, 0, 1);
        send_word(encode(9) ^ 2, 0);
        tick(0, 1, 1, 0); for (int i = 0; i < 5; i++) tick(0, 1, 0, 1);
        send_word(encode(5), 0);
        idle(10);

        // R2: stray valid bits without a word start produce nothing
        tag = "R2";
        for (int i = 0; i < 9; i++) tick(0, 1, 0, i[0]);
        idle(4);
        send_word(encode(12) ^ 64, 0);
        for (int i = 0; i < 5; i++) tick(0, 1, 0, 1);
        idle(10);

        // R1: reset in the middle of a word discards it
        tag = "R1";
        tick(0, 1, 1, 1); tick(0, 1, 0, 1); tick(0, 1, 0, 0);
        tick(1, 0, 0, 0);
        for (int i = 0; i < 4; i++) tick(0, 1, 0, 1);
        idle(8);
        tag = "R9";
        send_word(encode(3) ^ 8, 0);
        idle(10);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule